// File: doc/BRIEF.md
# TLB-Backed Address Translation Unit

This block maps a 14-bit virtual address onto a 12-bit physical address for a small paged memory with 64-byte pages. The low six bits are the page offset, and they pass through unchanged. The upper eight virtual bits select a page, and the upper six physical bits name a frame. Each request first searches an eight-entry fully associative translation cache. If the page is cached, the answer comes back on the next cycle.

On a cache miss the unit fetches one 10-bit page-table entry through a read port. The entry address is the page-table base input plus the virtual page number, so the table is single-level and directly indexed. If the entry is valid, it is loaded into the cache and the access is checked. If the entry is not valid, the unit reports a page fault and loads nothing.

Every completed request produces exactly one of three results:
- a physical address,
- a page fault, or
- a protection fault.

A protection fault means the access kind is not allowed by the page's rights, or a user-mode access touched a kernel-only page. A flush input drops every cached translation, for use on a context switch. Only one request is in flight at a time, and `req_ready` shows when a new request can be taken.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `pt_rd_en` is 0.
- R2: A request whose page is cached gets `rsp_valid` exactly one cycle after acceptance. A good result is `rsp_paddr` = {cached frame number, virtual address bits 5:0}.
- R3: On a cache miss:
  - `pt_rd_en` is high for exactly one cycle, in the cycle after acceptance.
  - `pt_rd_addr` = `pt_base` + virtual page number, modulo 2^12.
  - The port returns data one cycle after the read.
  - `rsp_valid` arrives three cycles after acceptance.
  - `req_ready` stays low until the response.
- R4: A page-table entry has bit 9 = valid, bits 8:7 = rights, bit 6 = kernel-only and bits 5:0 = frame number.
- R5: A fetched entry with bit 9 clear gives `rsp_fault_page`=1, `rsp_fault_prot`=0 and `rsp_paddr`=0. Such an entry is never cached, so repeating the request misses again.
- R6: Access kind is encoded as 00 read, 01 write, 10 execute. Rights are encoded as follows:
  - 00 allows read only.
  - 01 allows read and write.
  - 10 allows execute only.
  - 11 allows nothing.

  A disallowed access gives `rsp_fault_prot`=1, `rsp_fault_page`=0 and `rsp_paddr`=0.
- R7: With `req_user`=1, any access to a page whose kernel-only bit is set is a protection fault. With `req_user`=0, the kernel-only bit has no effect.
- R8: The cache holds eight entries and refills in round-robin order. After eight further distinct fills, the oldest entry is evicted and the others still hit.
- R9: `flush` clears all cached entries in one cycle. A request presented in the same cycle as `flush` is handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when both high |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| pt_base | input | 12 | Page-table base address |
| flush | input | 1 | Invalidate all cached translations |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 12 | Physical address (0 on fault) |
| rsp_fault_page | output | 1 | Page not resident |
| rsp_fault_prot | output | 1 | Access rights or privilege violation |
| pt_rd_en | output | 1 | Page-table read request |
| pt_rd_addr | output | 12 | Page-table entry address |
| pt_rd_data | input | 10 | Entry data, valid one cycle after the read |

## Verification
A request is accepted at a clock edge. A cached hit raises `rsp_valid` after that edge. A miss shows `pt_rd_en` after that edge, gets its data after the next edge, and gives its result after the third edge. The bench drives each request on a falling edge and then counts falling edges until `rsp_valid` is seen. It compares that count with the expected latency of 1 or 3, so a result that comes early or late is reported. The table-read address and the busy indication are checked on the falling edge where the read is visible.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W  = 14;
    parameter int PA_W  = 12;
    parameter int OFF_W = 6;
    parameter int PT_AW = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int PTE_W = PPN_W + 4;
    localparam int PTE_VALID_BIT = PPN_W + 3;
    localparam int PTE_RT_HI     = PPN_W + 2;
    localparam int PTE_RT_LO     = PPN_W + 1;
    localparam int PTE_KERN_BIT  = PPN_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RT_RO   = 2'b00,
        RT_RW   = 2'b01,
        RT_XO   = 2'b10,
        RT_NONE = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RDREQ  = 2'b01,
        ST_RDWAIT = 2'b10
    } walk_st_e;
endpackage

// File: rtl/xlat_rights.sv
module xlat_rights
    import xlat_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] rights,
    input  logic       kern_only,
    input  logic       user_mode,
    output logic       allow
);
    logic kind_ok;

    always_comb begin
        kind_ok = 1'b0;
        case (rights_e'(rights))
            RT_RO:   kind_ok = (kind == ACC_READ);
            RT_RW:   kind_ok = (kind == ACC_READ) || (kind == ACC_WRITE);
            RT_XO:   kind_ok = (kind == ACC_EXEC);
            default: kind_ok = 1'b0;
        endcase
        allow = kind_ok && !(user_mode && kern_only);
    end

    // R7: user access to a kernel-only page is never allowed
    always_comb begin
        if (user_mode && kern_only) begin
            a_user_kern_r7: assert (!allow);
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic [1:0]       hit_rights,
    output logic             hit_kern,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_rights,
    input  logic             fill_kern
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [VPN_W-1:0] tag;
        logic [1:0]       rights;
        logic             kern;
        logic [PPN_W-1:0] ppn;
    } ent_t;

    typedef struct packed {
        logic [ENTRIES-1:0] valid;
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   ptr;
    } tlb_st_t;

    tlb_st_t s_d, s_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = s_q.valid[g] && (s_q.ent[g].tag == lk_vpn);
    end

    always_comb begin
        hit        = |match;
        hit_ppn    = '0;
        hit_rights = '0;
        hit_kern   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_ppn    = hit_ppn    | s_q.ent[i].ppn;
                hit_rights = hit_rights | s_q.ent[i].rights;
                hit_kern   = hit_kern   | s_q.ent[i].kern;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.valid = '0;
        end else if (fill_en) begin
            s_d.ent[s_q.ptr].tag    = fill_vpn;
            s_d.ent[s_q.ptr].ppn    = fill_ppn;
            s_d.ent[s_q.ptr].rights = fill_rights;
            s_d.ent[s_q.ptr].kern   = fill_kern;
            s_d.valid[s_q.ptr]      = 1'b1;
            s_d.ptr = (s_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: fills never create two entries for the same page
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9: nothing hits in the cycle after a flush
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [PT_AW-1:0] pt_base,
    input  logic             flush,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault_page,
    output logic             rsp_fault_prot,
    output logic             pt_rd_en,
    output logic [PT_AW-1:0] pt_rd_addr,
    input  logic [PTE_W-1:0] pt_rd_data
);
    typedef struct packed {
        walk_st_e         st;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        logic [1:0]       kind;
        logic             user;
        logic [PT_AW-1:0] pt_addr;
        logic             rsp_valid;
        logic [PA_W-1:0]  paddr;
        logic             fpage;
        logic             fprot;
    } unit_st_t;

    unit_st_t s_d, s_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             tlb_hit, hit_kern, use_hit;
    logic [PPN_W-1:0] hit_ppn;
    logic [1:0]       hit_rights;
    logic             pte_valid, pte_kern;
    logic [1:0]       pte_rights;
    logic [PPN_W-1:0] pte_ppn;
    logic             fill_en;
    logic [1:0]       chk_kind, chk_rights;
    logic             chk_kern, chk_user, allow;

    assign req_vpn    = req_vaddr[VA_W-1:OFF_W];
    assign req_off    = req_vaddr[OFF_W-1:0];
    assign pte_valid  = pt_rd_data[PTE_VALID_BIT];
    assign pte_rights = pt_rd_data[PTE_RT_HI:PTE_RT_LO];
    assign pte_kern   = pt_rd_data[PTE_KERN_BIT];
    assign pte_ppn    = pt_rd_data[PPN_W-1:0];
    assign use_hit    = tlb_hit && !flush;

    xlat_tlb #(.ENTRIES(TLB_ENTRIES)) tlb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .lk_vpn      (req_vpn),
        .hit         (tlb_hit),
        .hit_ppn     (hit_ppn),
        .hit_rights  (hit_rights),
        .hit_kern    (hit_kern),
        .fill_en     (fill_en),
        .fill_vpn    (s_q.vpn),
        .fill_ppn    (pte_ppn),
        .fill_rights (pte_rights),
        .fill_kern   (pte_kern)
    );

    always_comb begin
        if (s_q.st == ST_RDWAIT) begin
            chk_kind   = s_q.kind;
            chk_user   = s_q.user;
            chk_rights = pte_rights;
            chk_kern   = pte_kern;
        end else begin
            chk_kind   = req_kind;
            chk_user   = req_user;
            chk_rights = hit_rights;
            chk_kern   = hit_kern;
        end
    end

    xlat_rights rights_i (
        .kind      (chk_kind),
        .rights    (chk_rights),
        .kern_only (chk_kern),
        .user_mode (chk_user),
        .allow     (allow)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        fill_en       = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (use_hit) begin
                        s_d.rsp_valid = 1'b1;
                        s_d.fpage     = 1'b0;
                        s_d.fprot     = !allow;
                        s_d.paddr     = allow ? {hit_ppn, req_off} : '0;
                    end else begin
                        s_d.st      = ST_RDREQ;
                        s_d.vpn     = req_vpn;
                        s_d.off     = req_off;
                        s_d.kind    = req_kind;
                        s_d.user    = req_user;
                        s_d.pt_addr = pt_base + PT_AW'(req_vpn);
                    end
                end
            end
            ST_RDREQ: begin
                s_d.st = ST_RDWAIT;
            end
            ST_RDWAIT: begin
                s_d.st        = ST_IDLE;
                s_d.rsp_valid = 1'b1;
                if (!pte_valid) begin
                    s_d.fpage = 1'b1;
                    s_d.fprot = 1'b0;
                    s_d.paddr = '0;
                end else begin
                    fill_en   = 1'b1;
                    s_d.fpage = 1'b0;
                    s_d.fprot = !allow;
                    s_d.paddr = allow ? {pte_ppn, s_q.off} : '0;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready      = (s_q.st == ST_IDLE);
    assign pt_rd_en       = (s_q.st == ST_RDREQ);
    assign pt_rd_addr     = s_q.pt_addr;
    assign rsp_valid      = s_q.rsp_valid;
    assign rsp_paddr      = s_q.paddr;
    assign rsp_fault_page = s_q.fpage;
    assign rsp_fault_prot = s_q.fprot;

    // R2: a cached page answers on the next cycle
    p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && tlb_hit && !flush) |=> rsp_valid);

    // R3: a miss issues the table read on the next cycle
    p_walk_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !(tlb_hit && !flush)) |=> pt_rd_en);

    // R3: the result follows two cycles after the read, and the read is single
    p_walk_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> (!pt_rd_en && !req_ready) ##1 rsp_valid);

    // R5: a faulting response carries no address
    p_fault_noaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault_page || rsp_fault_prot)) |-> (rsp_paddr == '0));

    // R6: the two fault kinds never appear together
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_fault_page && rsp_fault_prot));
endmodule

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] BASE = 12'h3C0;

    typedef struct packed {
        logic [7:0] vpn;
        logic [5:0] off;
        logic [1:0] kind;
        logic       user;
        logic [1:0] lat;
    } vec_t;

    // kind 0 read, 1 write, 2 exec; user 1 = user mode
    localparam vec_t VEC [12] = '{
        '{8'h00, 6'h05, 2'd0, 1'b1, 2'd3},  // miss, RO read ok
        '{8'h00, 6'h3F, 2'd0, 1'b1, 2'd1},  // hit, offset passes
        '{8'h00, 6'h11, 2'd1, 1'b1, 2'd1},  // hit, write on RO -> prot
        '{8'h08, 6'h2A, 2'd1, 1'b1, 2'd3},  // miss, RW write ok
        '{8'h08, 6'h01, 2'd2, 1'b1, 2'd1},  // hit, exec on RW -> prot
        '{8'h10, 6'h0C, 2'd2, 1'b1, 2'd3},  // miss, XO exec ok
        '{8'h10, 6'h0C, 2'd0, 1'b1, 2'd1},  // hit, read on XO -> prot
        '{8'h20, 6'h33, 2'd0, 1'b1, 2'd3},  // miss, user on kernel page -> prot (R7)
        '{8'h20, 6'h33, 2'd0, 1'b0, 2'd1},  // hit, kernel mode ok (R7)
        '{8'h07, 6'h00, 2'd0, 1'b0, 2'd3},  // miss, not resident
        '{8'h07, 6'h00, 2'd0, 1'b0, 2'd3},  // miss again: not cached (R5)
        '{8'h08, 6'h3E, 2'd0, 1'b0, 2'd1}   // hit, RW read ok
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic [11:0] rsp_paddr;
    logic        rsp_fault_page, rsp_fault_prot;
    logic        pt_rd_en;
    logic [11:0] pt_rd_addr;
    logic [9:0]  pt_rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_kind       (req_kind),
        .req_user       (req_user),
        .pt_base        (BASE),
        .flush          (flush),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault_page (rsp_fault_page),
        .rsp_fault_prot (rsp_fault_prot),
        .pt_rd_en       (pt_rd_en),
        .pt_rd_addr     (pt_rd_addr),
        .pt_rd_data     (pt_rd_data)
    );

    // entry layout (R4): [9] valid, [8:7] rights, [6] kernel-only, [5:0] frame
    function automatic logic [9:0] pte_of(input logic [7:0] vpn);
        logic [1:0] rt;
        rt = (vpn[4:3] == 2'b11) ? 2'b01 : vpn[4:3];
        return {(vpn[2:0] != 3'd7), rt, vpn[5], vpn[5:0] ^ 6'h2A};
    endfunction

    always @(posedge clk) begin
        if (pt_rd_en) pt_rd_data <= pte_of(8'(pt_rd_addr - BASE));
    end

    function automatic bit rule_ok(input logic [1:0] kind, input logic [1:0] rt);
        case (rt)
            2'b00:   return kind == 2'd0;
            2'b01:   return kind == 2'd0 || kind == 2'd1;
            2'b10:   return kind == 2'd2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_req(input logic [7:0] vpn, input logic [5:0] off,
                          input logic [1:0] kind, input logic user,
                          input logic fl, input int exp_lat, input string tag);
        int lat;
        logic [9:0] p;
        logic efp, efr;
        logic [11:0] epa;
        @(negedge clk);
        req_vaddr = {vpn, off};
        req_kind  = kind;
        req_user  = user;
        flush     = fl;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        flush     = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            if (pt_rd_en) begin
                chk(pt_rd_addr == BASE + 12'(vpn), "R3 table address",
                    int'(pt_rd_addr), int'(BASE + 12'(vpn)));
                chk(!req_ready, "R3 busy during walk", int'(req_ready), 0);
            end
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, tag, lat, exp_lat);
        p = pte_of(vpn);
        efp = !p[9];
        efr = p[9] && !((!(user && p[6])) && rule_ok(kind, p[8:7]));
        epa = (efp || efr) ? 12'h000 : {p[5:0], off};
        chk(rsp_fault_page == efp, "R5 page fault", int'(rsp_fault_page), int'(efp));
        chk(rsp_fault_prot == efr, "R6/R7 protection fault", int'(rsp_fault_prot), int'(efr));
        chk(rsp_paddr == epa, "R2/R4 physical address", int'(rsp_paddr), int'(epa));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(pt_rd_en == 1'b0, "R1 pt_rd_en", int'(pt_rd_en), 0);

        foreach (VEC[i]) begin
            do_req(VEC[i].vpn, VEC[i].off, VEC[i].kind, VEC[i].user, 1'b0,
                   int'(VEC[i].lat), (VEC[i].lat == 2'd1) ? "R2 hit latency" : "R3 miss latency");
        end

        // R9: flush alone, then a previously cached page misses
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        do_req(8'h00, 6'h02, 2'd0, 1'b0, 1'b0, 3, "R9 miss after flush");

        // R8: round-robin eviction over nine distinct fills after a flush
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 0; k < 9; k++) begin
            do_req(8'(k * 8), 6'h04, 2'd0, 1'b0, 1'b0, 3, "R8 fill latency");
        end
        do_req(8'h10, 6'h04, 2'd0, 1'b0, 1'b0, 1, "R8 younger entry still hits");
        do_req(8'h00, 6'h04, 2'd0, 1'b0, 1'b0, 3, "R8 oldest entry evicted");
        do_req(8'h08, 6'h04, 2'd0, 1'b0, 1'b0, 3, "R8 next oldest evicted");
        do_req(8'h08, 6'h04, 2'd0, 1'b0, 1'b0, 1, "R8 refilled entry hits");

        // R9: request presented with flush is treated as a miss
        do_req(8'h08, 6'h09, 2'd0, 1'b0, 1'b1, 3, "R9 request with flush misses");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule